// File: doc/BRIEF.md
# Lockable Watchdog Timer

The block is a watchdog counter for a small controller. It counts qualifying pulses from one of two clock enables: a slow internal oscillator tick or a system-clock enable. When the count reaches the selected overflow length, it raises a one-cycle reset request. An 8-bit mode register chooses the count source and one of eight overflow lengths. After each reset, only the first write to this register takes effect, so later code cannot weaken the configuration. A strap input ties the watchdog to the slow oscillator and keeps it from being stopped.

Software keeps the timer alive by writing a restart key to a second register, the enable register. Any other value written there is treated as a fault and asserts the reset request at once. The overflow exponents come from two base parameters, one for each source. Period code n selects 2^(base+n) pulses.

Top module: `wdog_lockable`

## Requirements
- R1: After reset the mode register reads 0x67 and `rst_req_o` is low. The timer then counts slow ticks with period code 7.
- R2: The first mode write after reset is accepted and reads back as {3'b011, data[4:0]}. Every later mode write is ignored and leaves the read value unchanged.
- R3: With mode bit 4 = 0, the timer overflows after 2^(SLOW_EXP_BASE+n) slow ticks, where n is mode bits 2:0. Fast ticks have no effect in this mode.
- R4: With mode bits 4:3 = 10, the timer overflows after 2^(FAST_EXP_BASE+n) fast ticks. Slow ticks have no effect in this mode.
- R5: With mode bits 4:3 = 11 and the strap low, the counter holds at zero and no overflow occurs.
- R6: While `strap_slow_i` is high, the timer counts slow ticks whatever the mode bits 4:3 select, including 11.
- R7: Writing 0xAC to the enable register (`reg_sel_i` = 1) restarts the count from zero. A tick in the same cycle is discarded.
- R8: Writing any value other than 0xAC to the enable register sets `rst_req_o` high in the cycle after the write. This holds in every mode, including stop.
- R9: `rst_req_o` goes high for exactly one cycle, in the cycle after the edge that samples the overflowing tick. Counting then resumes from zero.
- R10: An accepted mode write restarts the count from zero. An ignored mode write leaves the count untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = mode, 1 = enable |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Mode register read value |
| slow_tick_i | input | 1 | Slow oscillator enable pulse, synchronous to clk_i |
| fast_tick_i | input | 1 | System-clock count enable |
| strap_slow_i | input | 1 | Forces the slow source and prevents stopping |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The bench drives long runs of the inactive source before the active one. A design that counts both enables therefore overflows early and produces an unexpected pulse. It checks the exact overflow cycle after a restart key sent one tick short of overflow, and after an accepted mode write made in the middle of a count. A design that fails to clear the count in either case fires too soon. It checks that an ignored second mode write neither changes the read value nor resets the count, which catches both a lock that leaks and a clear that fires on the rejected write. It runs the stop encoding with and without the strap, and sends a bad key in stop mode. A timer that obeys stop under the strap stays silent, and one that gates the fault with stop misses the expected pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] MODE_RST_VAL = 8'h67;
  localparam logic [2:0] MODE_FIXED   = 3'b011;
  localparam logic [7:0] KICK_KEY     = 8'hAC;
  localparam logic       SEL_MODE     = 1'b0;
  localparam logic       SEL_KICK     = 1'b1;
  localparam int unsigned PERIOD_CODES = 8;

  typedef enum logic [1:0] {
    CS_SLOW_A = 2'b00,
    CS_SLOW_B = 2'b01,
    CS_FAST   = 2'b10,
    CS_STOP   = 2'b11
  } clk_sel_e;
endpackage

// File: rtl/wdog_mode_reg.sv
module wdog_mode_reg
  import wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [4:0] wdata_i,
  output logic [7:0] mode_o,
  output logic       locked_o,
  output logic       accept_o
);
  logic [7:0] mode_q;
  logic       locked_q;

  assign accept_o = we_i && !locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_RST_VAL;
      locked_q <= 1'b0;
    end else if (accept_o) begin
      mode_q   <= {MODE_FIXED, wdata_i};
      locked_q <= 1'b1;
    end
  end

  assign mode_o   = mode_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/wdog_src_sel.sv
module wdog_src_sel
  import wdog_pkg::*;
(
  input  logic [1:0] clk_sel_i,
  input  logic       strap_slow_i,
  input  logic       slow_tick_i,
  input  logic       fast_tick_i,
  output logic       tick_o,
  output logic       use_fast_o,
  output logic       stop_o
);
  clk_sel_e sel;

  always_comb begin
    sel = clk_sel_e'(clk_sel_i);
    // strap overrides both fast select and stop
    if (strap_slow_i) sel = CS_SLOW_A;
  end

  always_comb begin
    tick_o     = 1'b0;
    use_fast_o = 1'b0;
    stop_o     = 1'b0;
    unique case (sel)
      CS_SLOW_A, CS_SLOW_B: tick_o = slow_tick_i;
      CS_FAST: begin
        tick_o     = fast_tick_i;
        use_fast_o = 1'b1;
      end
      CS_STOP: stop_o = 1'b1;
      default: stop_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned SLOW_EXP_BASE = 11,
  parameter int unsigned FAST_EXP_BASE = 13,
  parameter int unsigned CW            = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          stop_i,
  input  logic          clear_i,
  input  logic          use_fast_i,
  input  logic [2:0]    period_i,
  output logic [CW-1:0] cnt_o,
  output logic          hit_o
);
  logic [CW-1:0] lim_slow [PERIOD_CODES];
  logic [CW-1:0] lim_fast [PERIOD_CODES];
  logic [CW-1:0] target;
  logic [CW-1:0] cnt_q;

  for (genvar g = 0; g < PERIOD_CODES; g++) begin : g_lim
    localparam int unsigned ES = SLOW_EXP_BASE + g;
    localparam int unsigned EF = FAST_EXP_BASE + g;
    assign lim_slow[g] = CW'((64'd1 << ES) - 64'd1);
    assign lim_fast[g] = CW'((64'd1 << EF) - 64'd1);
  end

  assign target = use_fast_i ? lim_fast[period_i] : lim_slow[period_i];
  assign hit_o  = tick_i && !stop_i && !clear_i && (cnt_q == target);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clear_i || stop_i) cnt_q <= '0;
    else if (hit_o)             cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
  import wdog_pkg::*;
#(
  parameter int unsigned SLOW_EXP_BASE = 11,
  parameter int unsigned FAST_EXP_BASE = 13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic       reg_sel_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       slow_tick_i,
  input  logic       fast_tick_i,
  input  logic       strap_slow_i,
  output logic       rst_req_o
);
  localparam int unsigned MAX_BASE = (FAST_EXP_BASE > SLOW_EXP_BASE) ? FAST_EXP_BASE : SLOW_EXP_BASE;
  localparam int unsigned CW       = MAX_BASE + PERIOD_CODES - 1;

  logic          mode_we, kick_we, kick_ok, kick_bad;
  logic [7:0]    mode_q;
  logic          locked_q, mode_acc;
  logic          tick_w, use_fast_w, stop_w, hit_w;
  logic [CW-1:0] cnt_q;
  logic          rst_req_q;

  assign mode_we  = reg_we_i && (reg_sel_i == SEL_MODE);
  assign kick_we  = reg_we_i && (reg_sel_i == SEL_KICK);
  assign kick_ok  = kick_we && (reg_wdata_i == KICK_KEY);
  assign kick_bad = kick_we && (reg_wdata_i != KICK_KEY);

  wdog_mode_reg u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (mode_we),
    .wdata_i  (reg_wdata_i[4:0]),
    .mode_o   (mode_q),
    .locked_o (locked_q),
    .accept_o (mode_acc)
  );

  wdog_src_sel u_src (
    .clk_sel_i    (mode_q[4:3]),
    .strap_slow_i (strap_slow_i),
    .slow_tick_i  (slow_tick_i),
    .fast_tick_i  (fast_tick_i),
    .tick_o       (tick_w),
    .use_fast_o   (use_fast_w),
    .stop_o       (stop_w)
  );

  wdog_counter #(
    .SLOW_EXP_BASE (SLOW_EXP_BASE),
    .FAST_EXP_BASE (FAST_EXP_BASE),
    .CW            (CW)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_w),
    .stop_i     (stop_w),
    .clear_i    (kick_ok || mode_acc),
    .use_fast_i (use_fast_w),
    .period_i   (mode_q[2:0]),
    .cnt_o      (cnt_q),
    .hit_o      (hit_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= hit_w || kick_bad;
  end

  assign rst_req_o   = rst_req_q;
  assign reg_rdata_o = mode_q;
endmodule

// File: rtl/wdog_lockable_chk.sv
module wdog_lockable_chk
  import wdog_pkg::*;
#(
  parameter int unsigned CW = 20
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic          reg_sel_i,
  input logic [7:0]    reg_wdata_i,
  input logic          rst_req_o,
  input logic [7:0]    mode_q,
  input logic          locked_q,
  input logic [CW-1:0] cnt_q,
  input logic          stop_w
);
  logic mode_we, kick_we;
  assign mode_we = reg_we_i && (reg_sel_i == SEL_MODE);
  assign kick_we = reg_we_i && (reg_sel_i == SEL_KICK);

  assert_first_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we && !locked_q) |=> (mode_q == {MODE_FIXED, $past(reg_wdata_i[4:0])}));

  assert_locked_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we && locked_q) |=> (mode_q == $past(mode_q)));

  assert_stop_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> (cnt_q == '0));

  assert_kick_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_we && reg_wdata_i == KICK_KEY) |=> (cnt_q == '0));

  assert_bad_kick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_we && reg_wdata_i != KICK_KEY) |=> rst_req_o);
endmodule

bind wdog_lockable wdog_lockable_chk #(.CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .rst_req_o   (rst_req_o),
  .mode_q      (mode_q),
  .locked_q    (locked_q),
  .cnt_q       (cnt_q),
  .stop_w      (stop_w)
);

// File: tb/wdog_lockable_tb.sv
module wdog_lockable_tb;
  localparam int unsigned SB = 2;
  localparam int unsigned FB = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic       reg_sel_i = 1'b0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       slow_tick_i = 1'b0;
  logic       fast_tick_i = 1'b0;
  logic       strap_slow_i = 1'b0;
  logic       rst_req_o;

  always #5 clk_i = ~clk_i;

  wdog_lockable #(.SLOW_EXP_BASE(SB), .FAST_EXP_BASE(FB)) u_dut (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i, .reg_rdata_o,
    .slow_tick_i, .fast_tick_i, .strap_slow_i, .rst_req_o
  );

  typedef struct { int cyc; string req; } exp_t;
  exp_t  exp_q[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: every pulse must match the head of the queue
  always @(negedge clk_i) begin
    if (rst_ni && rst_req_o) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL %s: unexpected reset request at cycle %0d (actual 1, expected 0)", cur_req, cyc);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.cyc != cyc) begin
          n_fail++;
          $display("FAIL %s: reset request at cycle %0d, expected cycle %0d", e.req, cyc, e.cyc);
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic drain(input string req);
    @(negedge clk_i);
    check(req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk_i);
    rst_ni = 1'b0;
    strap_slow_i = strap;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic drive_ticks(input logic s, input logic f, input int n, input bit pulse, input string req);
    @(negedge clk_i);
    cur_req = req;
    if (pulse) exp_q.push_back('{cyc + n, req});
    for (int i = 0; i < n; i++) begin
      slow_tick_i = s;
      fast_tick_i = f;
      @(negedge clk_i);
    end
    slow_tick_i = 1'b0;
    fast_tick_i = 1'b0;
  endtask

  task automatic reg_write(input logic sel, input logic [7:0] d, input string req);
    @(negedge clk_i);
    cur_req = req;
    if (sel == 1'b1 && d != 8'hAC) exp_q.push_back('{cyc + 1, req});
    reg_we_i = 1'b1;
    reg_sel_i = sel;
    reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  initial begin
    // A: default mode, slow n=7 -> 2^9 ticks
    do_reset(1'b0);
    @(negedge clk_i);
    check("R1 mode reset value", reg_rdata_o, 8'h67);
    check("R1 rst_req low", rst_req_o, 0);
    drive_ticks(1'b0, 1'b1, 512, 1'b0, "R3 fast ignored in slow mode");
    drive_ticks(1'b1, 1'b0, 511, 1'b0, "R7 before kick");
    reg_write(1'b1, 8'hAC, "R7 kick");
    drive_ticks(1'b1, 1'b0, 512, 1'b1, "R7 full period after kick");
    drive_ticks(1'b1, 1'b0, 512, 1'b1, "R9 restart after overflow");
    drain("R9 pulses seen");

    // B: slow n=2 -> 16 ticks, lock
    do_reset(1'b0);
    reg_write(1'b0, 8'h0A, "R2 first write");
    check("R2 read accepted", reg_rdata_o, 8'h6A);
    drive_ticks(1'b0, 1'b1, 20, 1'b0, "R3 fast ignored");
    drive_ticks(1'b1, 1'b0, 10, 1'b0, "R10 partial");
    reg_write(1'b0, 8'h13, "R2 second write");
    check("R2 second write ignored", reg_rdata_o, 8'h6A);
    drive_ticks(1'b1, 1'b0, 6, 1'b1, "R10 ignored write keeps count");
    drain("R3 slow overflow");

    // C: fast n=5 -> 256 ticks
    do_reset(1'b0);
    reg_write(1'b0, 8'h15, "R4 mode write");
    check("R4 read", reg_rdata_o, 8'h75);
    drive_ticks(1'b1, 1'b0, 300, 1'b0, "R4 slow ignored");
    drive_ticks(1'b0, 1'b1, 256, 1'b1, "R4 fast overflow");
    drain("R4 fast overflow");

    // D: stop
    do_reset(1'b0);
    reg_write(1'b0, 8'hF8, "R5 stop write");
    check("R5 read", reg_rdata_o, 8'h78);
    drive_ticks(1'b1, 1'b1, 1100, 1'b0, "R5 stopped");
    reg_write(1'b1, 8'h55, "R8 bad key in stop");
    drain("R8 bad key pulse");

    // E: strap overrides stop, slow n=0 -> 4 ticks
    do_reset(1'b1);
    reg_write(1'b0, 8'h18, "R6 stop under strap");
    drive_ticks(1'b0, 1'b1, 10, 1'b0, "R6 fast ignored under strap");
    drive_ticks(1'b1, 1'b0, 4, 1'b1, "R6 strap slow overflow");
    drain("R6 strap");
    reg_write(1'b1, 8'h00, "R8 bad key zero");
    drain("R8 bad key zero");

    // F: accepted mode write clears count
    do_reset(1'b0);
    drive_ticks(1'b1, 1'b0, 300, 1'b0, "R10 pre-count");
    reg_write(1'b0, 8'h07, "R10 accepted write");
    drive_ticks(1'b1, 1'b0, 512, 1'b1, "R10 count restarted");
    drain("R10 clear on accept");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung (actual running, expected done)");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule